// File: doc/BRIEF.md
# Bit-Reverse and Right-Align Unit

This unit takes a 64-bit data word, mirrors its bit order so that bit i moves to bit 63-i, and then shifts the mirrored word right by an amount taken from a second operand. The purpose is to reverse a field of any width from 1 to 64 bits and leave it right-aligned in the result. An example is reversing an index for an FFT address, or a CRC remainder of any length.

There are two ways to turn the count operand into a shift distance. In field mode the count names the top bit of the field. The shift is 63 minus the count, so a count of k reverses bits k..0 of the data into bits k..0 of the result. In count mode the shift equals the count, so a count of zero gives the plain full-width reversal. Only the low six bits of the count operand are used. The shift is logical. The result and a valid flag are registered, with one cycle of latency.

Top module: `bitrev_shift_unit`

## Requirements
- R1: While rstN is low, and on the first clock after it, outValid is 0 and outResult is all zeros.
- R2: outValid at each rising edge equals the inValid that was sampled at that edge, so the latency is one cycle.
- R3: With modeSel = 0 (field mode), a valid operation gives outResult = reverse(opData) >> (63 - opCount[5:0]), where reverse maps bit i to bit 63-i.
- R4: In field mode, a count of 63 gives the full reversal of opData, and a count of 0 gives opData bit 0 in bit 0 with all other bits zero.
- R5: With modeSel = 1 (count mode), a valid operation gives outResult = reverse(opData) >> opCount[5:0]. A count of 0 gives the full reversal.
- R6: Bits 63..6 of opCount have no effect. A count of 64+k gives the same result as k.
- R7: The shift fills with zeros. In field mode with count k, result bits 63..k+1 are zero.
- R8: When inValid is low, outResult keeps its previous value, whatever opData, opCount and modeSel carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation request for this cycle |
| modeSel | input | 1 | 0 = field mode, 1 = count mode |
| opData | input | 64 | Word to be reversed |
| opCount | input | 64 | Count operand; only bits 5..0 are used |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outResult | output | 64 | Reversed and shifted result, held between operations |

## Verification
Two functions can fall in the same cycle here. A new result is captured while the previous one is being presented, and the mode can change on the very next operation. The bench issues back-to-back operations with opposite modes. In the cycle after that, it drops inValid while opData, opCount and modeSel carry new values. Each result is compared with a bench-side reference, and the output must then stay at the second result while outValid falls.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
  parameter int unsigned BR_DATA_W  = 64;
  localparam int unsigned BR_SHIFT_W = $clog2(BR_DATA_W);

  typedef enum logic {
    MODE_FIELD = 1'b0,
    MODE_COUNT = 1'b1
  } brMode_t;

  typedef struct packed {
    logic                  capture;
    logic [BR_SHIFT_W-1:0] shiftAmt;
  } brStrobe_t;
endpackage

// File: rtl/bitrev_ctrl.sv
module bitrev_ctrl
  import bitrev_pkg::*;
#(
  parameter int unsigned DATA_W  = BR_DATA_W,
  parameter int unsigned SHIFT_W = BR_SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              modeSel,
  input  logic [DATA_W-1:0] opCount,
  output brStrobe_t         strobe,
  output logic              outValid
);
  localparam logic [SHIFT_W-1:0] TOP_BIT = SHIFT_W'(DATA_W - 1);

  brMode_t           curMode;
  logic [SHIFT_W-1:0] cntLow;

  assign curMode = brMode_t'(modeSel);
  assign cntLow  = opCount[SHIFT_W-1:0];

  always_comb begin
    strobe.capture = inValid;
    unique case (curMode)
      MODE_FIELD: strobe.shiftAmt = TOP_BIT - cntLow;
      MODE_COUNT: strobe.shiftAmt = cntLow;
      default:    strobe.shiftAmt = cntLow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: one-cycle valid latency
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R6: upper count bits never alter the distance in count mode
  assert_count_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel && (|opCount[DATA_W-1:SHIFT_W])) |->
      (strobe.shiftAmt == opCount[SHIFT_W-1:0]));
endmodule

// File: rtl/bitrev_datapath.sv
module bitrev_datapath
  import bitrev_pkg::*;
#(
  parameter int unsigned DATA_W  = BR_DATA_W,
  parameter int unsigned SHIFT_W = BR_SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobe,
  input  logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] outResult
);
  logic [DATA_W-1:0] revWord;
  logic [DATA_W-1:0] stage [SHIFT_W+1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revWord[i] = opData[DATA_W-1-i];
  end

  assign stage[0] = revWord;
  for (genvar s = 0; s < SHIFT_W; s++) begin : g_shift
    assign stage[s+1] = strobe.shiftAmt[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               outResult <= '0;
    else if (strobe.capture) outResult <= stage[SHIFT_W];
  end

  // R8: result holds without a capture
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outResult));
  // R7: vacated upper bits are zero
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=>
      ((outResult >> (DATA_W - int'($past(strobe.shiftAmt)))) == '0));
  // R3/R5: result bit 0 comes from data bit (DATA_W-1-shift)
  assert_lsb_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=>
      (outResult[0] == $past(opData[DATA_W-1-int'(strobe.shiftAmt)])));
endmodule

// File: rtl/bitrev_shift_unit.sv
module bitrev_shift_unit
  import bitrev_pkg::*;
#(
  parameter int unsigned DATA_W  = BR_DATA_W,
  parameter int unsigned SHIFT_W = BR_SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              modeSel,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] opCount,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);
  brStrobe_t strobe;

  bitrev_ctrl #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .opCount(opCount), .strobe(strobe), .outValid(outValid)
  );

  bitrev_datapath #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opData(opData),
    .outResult(outResult)
  );

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && (outResult == '0)));
endmodule

// File: tb/test_bitrev_shift_unit.sv
`timescale 1ns/1ps
module test_bitrev_shift_unit;
  localparam int N = 8;
  localparam logic        V_MODE  [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] V_DATA  [N] = '{
    64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_00A5,
    64'h0123_4567_89AB_CDEF, 64'hF0F0_0000_1234_5678, 64'h8000_0000_0000_0001,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_AAAA_3333_CCCC};
  localparam logic [63:0] V_COUNT [N] = '{
    64'd7, 64'd31, 64'd15, 64'd4, 64'd40, 64'd63, 64'd12, 64'd1};

  logic clk = 0, rstN = 0, inValid = 0, modeSel = 0;
  logic [63:0] opData = '0, opCount = '0;
  logic outValid;
  logic [63:0] outResult;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitrev_shift_unit i_bitrev_shift_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .opData(opData), .opCount(opCount), .outValid(outValid), .outResult(outResult));

  function automatic logic [63:0] refModel(logic m, logic [63:0] d, logic [63:0] c);
    logic [63:0] r;
    int amt;
    for (int i = 0; i < 64; i++) r[i] = d[63-i];
    amt = m ? int'(c[5:0]) : 63 - int'(c[5:0]);
    return r >> amt;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(string req, logic m, logic [63:0] d, logic [63:0] c, logic [63:0] exp);
    @(negedge clk);
    inValid = 1; modeSel = m; opData = d; opCount = c;
    @(negedge clk);
    inValid = 0;
    check(req, outResult, exp);
    check("R2 valid", {63'd0, outValid}, 64'd1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 valid", {63'd0, outValid}, 64'd0);
    check("R1 result", outResult, 64'd0);
    rstN = 1;

    for (int i = 0; i < N; i++)
      runOp(V_MODE[i] ? "R5 table" : "R3 table", V_MODE[i], V_DATA[i], V_COUNT[i],
            refModel(V_MODE[i], V_DATA[i], V_COUNT[i]));

    runOp("R4 full", 1'b0, 64'd1, 64'd63, 64'h8000_0000_0000_0000);
    runOp("R4 bit0 set", 1'b0, 64'd1, 64'd0, 64'd1);
    runOp("R4 bit0 clear", 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 64'd0);
    runOp("R3 field4", 1'b0, 64'd1, 64'd3, 64'd8);
    runOp("R5 zero", 1'b1, 64'd1, 64'd0, 64'h8000_0000_0000_0000);
    runOp("R5 max", 1'b1, 64'd1, 64'd63, 64'd1);
    runOp("R6 wrap field", 1'b0, 64'd1, 64'd67, 64'd8);
    runOp("R6 all ones", 1'b0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    runOp("R6 wrap count", 1'b1, 64'd1, 64'h0000_0100_0000_0040, 64'h8000_0000_0000_0000);
    runOp("R7 zero fill", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 64'hFF);

    // back-to-back, mode flip, then idle with changing inputs
    @(negedge clk);
    inValid = 1; modeSel = 0; opData = 64'hA5; opCount = 64'd7;
    @(negedge clk);
    inValid = 1; modeSel = 1; opData = 64'hF; opCount = 64'd60;
    check("R3 back-to-back", outResult, refModel(1'b0, 64'hA5, 64'd7));
    @(negedge clk);
    inValid = 0; modeSel = 0; opData = 64'h1234; opCount = 64'd5;
    check("R5 back-to-back", outResult, 64'hF);
    check("R2 back-to-back", {63'd0, outValid}, 64'd1);
    @(negedge clk);
    check("R8 hold", outResult, 64'hF);
    check("R2 idle", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    check("R8 hold later", outResult, 64'hF);

    rstN = 0;
    @(negedge clk);
    check("R1 mid reset result", outResult, 64'd0);
    check("R1 mid reset valid", {63'd0, outValid}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule